// File: doc/BRIEF.md
# Shareable Interrupt Pulser for a Buffered Parallel Port

This block turns the service and error conditions of a buffered parallel port into one interrupt request. Service requests come from the DMA terminal count or from the buffer crossing its programmed fill or drain threshold. Error and acknowledge requests come from edges on the peripheral's fault and acknowledge lines. A global service mask gates the DMA and threshold sources. Clearing that mask while the threshold condition already holds raises a request at once.

Every request drives the interrupt pad low for a fixed number of clock cycles, then releases it to high impedance. Several ports can therefore share one wire. Requests that arrive while a pulse is active are absorbed into that pulse. The surrounding port logic supplies the control bits, the buffer fill level and the two thresholds. The block also reports the pad's output enable and its driven level as separate registered signals.

Top module: `ppi_irq_ctrl`

## Requirements
- R1: After reset, `irq_oe` is 0 and `irq_lvl` is 1 until a request occurs.
- R2: While `svc_mask` is 1, neither a terminal-count strobe nor a threshold condition produces a pulse.
- R3: With `svc_mask` 0 and `dma_mode` 1, a one-cycle `dma_tc` strobe starts a pulse on the next clock edge. With `dma_mode` 0, `dma_tc` has no effect.
- R4: With `svc_mask` 0, `dma_mode` 0 and `dir_rd` 0, a pulse starts when the free space (`FIFO_DEPTH - fill_level`) goes from below `wr_thresh` to at least `wr_thresh`. While the condition stays true, no further pulse follows.
- R5: With `svc_mask` 0, `dma_mode` 0 and `dir_rd` 1, a pulse starts when `fill_level` goes from below `rd_thresh` to at least `rd_thresh`.
- R6: Changing `svc_mask` from 1 to 0 while the selected threshold condition already holds starts a pulse on the next edge.
- R7: With `err_irq_n` 0, a high-to-low change on `fault_n` starts a pulse.
- R8: Changing `err_irq_n` from 1 to 0 while `fault_n` is low starts a pulse.
- R9: With `ack_irq_en` 1, a low-to-high change on `ack_n` starts a pulse. With `ack_irq_en` 0, such a change has no effect.
- R10: A pulse keeps `irq_oe` at 1, `irq_lvl` at 0 and `irq_pad` at 0 for exactly `PULSE_LEN` cycles. Afterwards `irq_oe` is 0, `irq_lvl` is 1 and the pad is high impedance.
- R11: A request seen while `irq_oe` is 1 neither lengthens the pulse nor causes a second pulse.
- R12: Both thresholds compare with "greater than or equal": a level exactly equal to the threshold counts as reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_mask | input | 1 | 1 masks the DMA and threshold sources |
| dma_mode | input | 1 | 1 selects DMA transfers, 0 selects programmed I/O |
| dir_rd | input | 1 | 0 means the host writes to the port, 1 means the host reads from it |
| err_irq_n | input | 1 | Active-low enable for the fault interrupt |
| ack_irq_en | input | 1 | Enable for the acknowledge interrupt |
| fill_level | input | CNT_W | Bytes currently held in the buffer |
| rd_thresh | input | CNT_W | Read-direction fill threshold |
| wr_thresh | input | CNT_W | Write-direction free-space threshold |
| dma_tc | input | 1 | One-cycle DMA terminal-count strobe |
| fault_n | input | 1 | Peripheral fault line level |
| ack_n | input | 1 | Peripheral acknowledge line level |
| irq_oe | output | 1 | Pad output enable, 1 during a pulse |
| irq_lvl | output | 1 | Level of the pulse: 0 during a pulse, otherwise 1 |
| irq_pad | output | 1 | Shared interrupt pad: 0 when driven, otherwise high impedance |

## Verification
A DMA terminal count and a falling fault line can reach the pulse generator on the same clock edge. The bench produces this by raising `dma_tc` in the same half-cycle in which it drops `fault_n`, with the fault interrupt enabled. It expects exactly one pulse of `PULSE_LEN` cycles, followed by quiet cycles with no second pulse. In a second case, an acknowledge edge arrives during a pulse that a terminal count has already started. The same rule applies there, and the bench counts the high cycles of `irq_oe` to show that the pulse was neither stretched nor repeated.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

  // One bit for each request source feeding the pulse generator
  typedef struct packed {
    logic dma_done;
    logic level_hit;
    logic fault;
    logic ack;
  } ppi_evt_t;

  function automatic logic evt_any(input ppi_evt_t e);
    return e.dma_done | e.level_hit | e.fault | e.ack;
  endfunction

endpackage

// File: rtl/ppi_rise_det.sv
module ppi_rise_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= sig;
  end

  assign rise = sig & ~prev_q;

endmodule

// File: rtl/ppi_thresh_eval.sv
module ppi_thresh_eval #(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             svc_mask,
  input  logic             dma_mode,
  input  logic             dir_rd,
  input  logic [CNT_W-1:0] fill_level,
  input  logic [CNT_W-1:0] rd_thresh,
  input  logic [CNT_W-1:0] wr_thresh,
  output logic             hit
);

  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(FIFO_DEPTH);

  logic [CNT_W-1:0] free_space;
  logic             rd_ok;
  logic             wr_ok;
  logic             armed;

  always_comb begin
    free_space = (fill_level > DEPTH_V) ? '0 : DEPTH_V - fill_level;
    rd_ok      = fill_level >= rd_thresh;
    wr_ok      = free_space >= wr_thresh;
    // The mask is part of the condition, so unmasking raises an edge
    armed      = ~svc_mask & ~dma_mode & (dir_rd ? rd_ok : wr_ok);
  end

  ppi_rise_det #(.RST_VAL(1'b0)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .sig  (armed),
    .rise (hit)
  );

endmodule

// File: rtl/ppi_pulse_gen.sv
module ppi_pulse_gen #(
  parameter int PULSE_LEN = 4,
  localparam int LEN_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic oe,
  output logic lvl
);

  localparam logic [LEN_W-1:0] LEN_V = LEN_W'(PULSE_LEN);

  logic [LEN_W-1:0] left_q;
  logic             busy;
  logic             start;

  assign busy  = left_q != '0;
  assign start = trig & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      oe     <= 1'b0;
      lvl    <= 1'b1;
    end else begin
      if (start)     left_q <= LEN_V;
      else if (busy) left_q <= left_q - 1'b1;
      oe  <= start | (left_q > LEN_W'(1));
      lvl <= ~(start | (left_q > LEN_W'(1)));
    end
  end

endmodule

// File: rtl/ppi_irq_ctrl.sv
module ppi_irq_ctrl #(
  parameter int FIFO_DEPTH = 16,
  parameter int PULSE_LEN  = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             svc_mask,
  input  logic             dma_mode,
  input  logic             dir_rd,
  input  logic             err_irq_n,
  input  logic             ack_irq_en,
  input  logic [CNT_W-1:0] fill_level,
  input  logic [CNT_W-1:0] rd_thresh,
  input  logic [CNT_W-1:0] wr_thresh,
  input  logic             dma_tc,
  input  logic             fault_n,
  input  logic             ack_n,
  output logic             irq_oe,
  output logic             irq_lvl,
  output logic             irq_pad
);
  import ppi_pkg::*;

  ppi_evt_t evt;
  logic     lvl_hit;
  logic     fault_rise;
  logic     ack_rise;
  logic     fault_cond;

  ppi_thresh_eval #(.FIFO_DEPTH(FIFO_DEPTH)) u_thr (
    .clk        (clk),
    .rst        (rst),
    .svc_mask   (svc_mask),
    .dma_mode   (dma_mode),
    .dir_rd     (dir_rd),
    .fill_level (fill_level),
    .rd_thresh  (rd_thresh),
    .wr_thresh  (wr_thresh),
    .hit        (lvl_hit)
  );

  // Enable falling and line falling both appear as a rise of this term
  assign fault_cond = ~err_irq_n & ~fault_n;

  ppi_rise_det #(.RST_VAL(1'b0)) u_fault (
    .clk  (clk),
    .rst  (rst),
    .sig  (fault_cond),
    .rise (fault_rise)
  );

  ppi_rise_det #(.RST_VAL(1'b1)) u_ack (
    .clk  (clk),
    .rst  (rst),
    .sig  (ack_n),
    .rise (ack_rise)
  );

  always_comb begin
    evt.dma_done  = ~svc_mask & dma_mode & dma_tc;
    evt.level_hit = lvl_hit;
    evt.fault     = fault_rise;
    evt.ack       = ack_irq_en & ack_rise;
  end

  ppi_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk  (clk),
    .rst  (rst),
    .trig (evt_any(evt)),
    .oe   (irq_oe),
    .lvl  (irq_lvl)
  );

  assign irq_pad = irq_oe ? 1'b0 : 1'bz;

endmodule

// File: rtl/ppi_irq_ctrl_chk.sv
module ppi_irq_ctrl_chk #(
  parameter int PULSE_LEN = 4
) (
  input logic clk,
  input logic rst,
  input logic svc_mask,
  input logic dma_mode,
  input logic err_irq_n,
  input logic ack_irq_en,
  input logic dma_tc,
  input logic fault_n,
  input logic ack_n,
  input logic irq_oe,
  input logic irq_lvl
);

  localparam int RUN_W = $clog2(PULSE_LEN + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (irq_oe) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk) $fell(rst) |-> !irq_oe && irq_lvl);

  p_mask_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (svc_mask && dma_mode && dma_tc && err_irq_n && !ack_irq_en && !irq_oe) |=> !irq_oe);

  p_tc_fires_r3: assert property (@(posedge clk) disable iff (rst)
    (!svc_mask && dma_mode && dma_tc && !irq_oe) |=> irq_oe);

  p_fault_fires_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !err_irq_n && $past(!err_irq_n) && $fell(fault_n) && !irq_oe) |=> irq_oe);

  p_ack_fires_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ack_irq_en && $rose(ack_n) && !irq_oe) |=> irq_oe);

  p_level_pair_r10: assert property (@(posedge clk) disable iff (rst)
    irq_lvl == !irq_oe);

  p_pulse_short_r11: assert property (@(posedge clk) disable iff (rst)
    irq_oe |-> run_q < RUN_W'(PULSE_LEN));

  p_pulse_full_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_oe) |-> run_q == RUN_W'(PULSE_LEN));

endmodule

bind ppi_irq_ctrl ppi_irq_ctrl_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (.*);

// File: tb/ppi_irq_ctrl_tb.sv
module ppi_irq_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int PLEN  = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          svc_mask = 1'b1;
  logic          dma_mode = 1'b0;
  logic          dir_rd = 1'b1;
  logic          err_irq_n = 1'b1;
  logic          ack_irq_en = 1'b0;
  logic [CW-1:0] fill_level = '0;
  logic [CW-1:0] rd_thresh = CW'(6);
  logic [CW-1:0] wr_thresh = CW'(4);
  logic          dma_tc = 1'b0;
  logic          fault_n = 1'b1;
  logic          ack_n = 1'b1;
  logic          irq_oe;
  logic          irq_lvl;
  logic          irq_pad;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ppi_irq_ctrl #(.FIFO_DEPTH(DEPTH), .PULSE_LEN(PLEN)) dut_i (
    .clk(clk), .rst(rst), .svc_mask(svc_mask), .dma_mode(dma_mode),
    .dir_rd(dir_rd), .err_irq_n(err_irq_n), .ack_irq_en(ack_irq_en),
    .fill_level(fill_level), .rd_thresh(rd_thresh), .wr_thresh(wr_thresh),
    .dma_tc(dma_tc), .fault_n(fault_n), .ack_n(ack_n),
    .irq_oe(irq_oe), .irq_lvl(irq_lvl), .irq_pad(irq_pad)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called just after the edge that should start a pulse
  task automatic see_pulse(input string req);
    int len = 0;
    check(req, int'(irq_oe), 1);
    check("R10 level", int'(irq_lvl), 0);
    check("R10 pad", int'(irq_pad === 1'b0), 1);
    for (int i = 0; i < 4 * PLEN; i++) begin
      if (!irq_oe) break;
      len++;
      @(negedge clk);
    end
    check({req, " length"}, len, PLEN);
    check("R10 released", int'(irq_lvl), 1);
  endtask

  task automatic quiet(input string req, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq_oe) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic t_reset();
    check("R1 oe", int'(irq_oe), 0);
    check("R1 lvl", int'(irq_lvl), 1);
  endtask

  task automatic t_dma();
    dir_rd = 1'b1; fill_level = '0;
    svc_mask = 1'b1; dma_mode = 1'b1;
    dma_tc = 1'b1; @(negedge clk); dma_tc = 1'b0;
    quiet("R2 tc masked", 4);
    svc_mask = 1'b0;
    dma_tc = 1'b1; @(negedge clk); dma_tc = 1'b0;
    see_pulse("R3");
    dma_mode = 1'b0;
    dma_tc = 1'b1; @(negedge clk); dma_tc = 1'b0;
    quiet("R3 no dma mode", 4);
  endtask

  task automatic t_write_thresh();
    svc_mask = 1'b1; dir_rd = 1'b0; dma_mode = 1'b0;
    fill_level = CW'(15); wr_thresh = CW'(4);
    quiet("R4 setup", 2);
    svc_mask = 1'b0;
    quiet("R4 below", 3);
    fill_level = CW'(13);
    quiet("R4 free3", 3);
    fill_level = CW'(12);
    @(negedge clk);
    see_pulse("R12 write equal");
    quiet("R4 held", 6);
    fill_level = CW'(8);
    quiet("R4 still true", 4);
  endtask

  task automatic t_read_thresh();
    svc_mask = 1'b1; fill_level = '0; dir_rd = 1'b1; rd_thresh = CW'(6);
    quiet("R5 setup", 2);
    svc_mask = 1'b0;
    quiet("R5 empty", 2);
    fill_level = CW'(5);
    quiet("R5 below", 3);
    fill_level = CW'(6);
    @(negedge clk);
    see_pulse("R5");
    svc_mask = 1'b1; fill_level = '0;
    quiet("R5 reset", 2);
    svc_mask = 1'b0;
    quiet("R5 rearm", 2);
    fill_level = CW'(6);
    @(negedge clk);
    see_pulse("R12 read equal");
  endtask

  task automatic t_unmask();
    svc_mask = 1'b1; dir_rd = 1'b1; fill_level = CW'(10);
    quiet("R2 level masked", 4);
    svc_mask = 1'b0;
    @(negedge clk);
    see_pulse("R6");
    svc_mask = 1'b1; fill_level = '0;
    quiet("R6 cleanup", 2);
    svc_mask = 1'b0;
  endtask

  task automatic t_fault();
    err_irq_n = 1'b0;
    quiet("R7 idle", 2);
    fault_n = 1'b0;
    @(negedge clk);
    see_pulse("R7");
    fault_n = 1'b1;
    quiet("R7 rise quiet", 3);
    err_irq_n = 1'b1; fault_n = 1'b0;
    quiet("R8 disabled", 3);
    err_irq_n = 1'b0;
    @(negedge clk);
    see_pulse("R8");
    fault_n = 1'b1; err_irq_n = 1'b1;
    quiet("R8 cleanup", 2);
  endtask

  task automatic t_ack();
    ack_irq_en = 1'b0; ack_n = 1'b0;
    quiet("R9 low", 2);
    ack_n = 1'b1;
    quiet("R9 disabled", 3);
    ack_irq_en = 1'b1; ack_n = 1'b0;
    quiet("R9 falling", 3);
    ack_n = 1'b1;
    @(negedge clk);
    see_pulse("R9");
  endtask

  task automatic t_merge();
    svc_mask = 1'b0; dma_mode = 1'b1; ack_irq_en = 1'b1; ack_n = 1'b0;
    quiet("R11 setup", 2);
    dma_tc = 1'b1; @(negedge clk); dma_tc = 1'b0;
    ack_n = 1'b1;
    see_pulse("R11 ack in pulse");
    quiet("R11 no second", 6);
    err_irq_n = 1'b0;
    quiet("R11 setup2", 2);
    dma_tc = 1'b1; fault_n = 1'b0;
    @(negedge clk); dma_tc = 1'b0;
    see_pulse("R11 same cycle");
    quiet("R11 single", 6);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dma();
    t_write_thresh();
    t_read_thresh();
    t_unmask();
    t_fault();
    t_ack();
    t_merge();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule